// File: doc/BRIEF.md
# Double-Buffered Coherent PWM Channel

This block generates a pulse-width modulated waveform on one pin. A counter advances on every tick of a programmable power-of-two clock divider. A period value sets how many ticks one cycle of the waveform lasts. A pulse-width value sets for how many of those ticks the pin is held active. Software writes these values into primary registers over a simple register bus. The comparison uses a second, buffered copy of each value. The buffered copy is refreshed as whole 16-bit words only when one waveform period ends and the next begins. Because of this, a half-finished update can never produce a malformed pulse.

The bus accepts 16-bit accesses with per-byte enables. It also accepts 32-bit accesses, which cover two neighbouring registers. A 32-bit write that sets period and pulse width together is treated as one update. If that write lands on the exact cycle where a period ends, the buffer refresh for that boundary is skipped: the next period runs on the values already in the buffers, and the new pair takes effect one period later.

When the channel is off, the pin acts as plain I/O. One control bit sets the pin level and another sets whether the pin is driven. A one-cycle request pulse and a sticky flag mark each period end. Period, pulse width and counter have no reset value. Software writes the counter first, then the pulse width, then the control register.

Top module: `pwm_coherent_chan`

The bus has no handshake. A write takes effect at the rising edge where `bus_wr` is high. Reads are combinational from `bus_addr`. There is no streaming data path, so no valid/ready flow control or back-pressure applies.

## Requirements
- R1: After reset the control register reads zero in bits 8:0. The pin is not driven (`pin_oe`=0), `pin_out`=0 and `req`=0.
- R2: Control register (index 3) bit layout: bit 0 enable, bit 1 polarity, bit 2 drive, bits 6:4 divider select, bit 8 flag, bit 9 pin level (read-only). While disabled, `pin_out` equals the polarity bit and `pin_oe` equals the drive bit. Bit 9 reads `pin_in`.
- R3: While enabled, `pin_oe`=1. The counter runs from 0 to P-1 over one period of P ticks, where P is the buffered period. The pin is active while the counter is below the buffered width W. Active means high when polarity is 1 and low when polarity is 0.
- R4: A buffered width of 0 keeps the pin inactive for the whole period. A width of P or more keeps it active for the whole period.
- R5: A tick occurs once every 2^S clocks, where S is the divider select. Any control write restarts the divider, so the first tick after it comes 2^S clocks later.
- R6: Writes to period (index 0) or width (index 1) made during a period do not change that period. The buffers take the primary values at the next period end.
- R7: A byte write changes only the enabled byte of a primary register. The buffer is then loaded with the full 16-bit word.
- R8: A 32-bit write at index 0 puts bits 31:16 into period and bits 15:0 into width. If it falls on the cycle of a period end, the buffers keep their contents for the following period. Values written to the primaries earlier in that period are not loaded either. The new pair is loaded at the end of that following period.
- R9: Any other 32-bit write at an even index acts as two 16-bit writes: bits 31:16 go to that index and bits 15:0 to the next index. A 32-bit write at an odd index changes nothing.
- R10: Writing the counter (index 2) also loads the same value into the primary period register. Reading index 2 returns the counter.
- R11: `req` is high for the single cycle in which a period ends, and that end sets the flag. Writing 0 to the flag bit clears it and writing 1 has no effect. If a period end and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wide | input | 1 | 1: 32-bit access, 0: 16-bit access |
| bus_addr | input | 2 | Register index |
| bus_be | input | 4 | Byte enables (bits 1:0 low half, bits 3:2 high half) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Level driven on the pin |
| pin_oe | output | 1 | Pin output enable |
| req | output | 1 | One-cycle period-end request |

## Verification
Two pairs of events can fall in the same cycle: a period end with its buffer refresh and a paired period/width write, and a period end setting the flag with a software write that clears it. The bench provokes both the same way. It waits on a falling edge for `req` to rise, then places the write so that it lands on the very next rising edge, which is the period boundary. For the paired write, it measures the length and active count of the next two periods: the first must show the buffered values and ignore an earlier mid-period write, and the second must show the new pair. For the flag, it reads the control register afterwards and expects the flag to be set.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_PERIOD = 2'd0,
    REG_WIDTH  = 2'd1,
    REG_COUNT  = 2'd2,
    REG_CTRL   = 2'd3
  } reg_idx_e;

  // control register bit positions
  localparam int CB_EN      = 0;
  localparam int CB_POL     = 1;
  localparam int CB_DRV     = 2;
  localparam int CB_DIV_LO  = 4;
  localparam int CB_FLAG    = 8;
  localparam int CB_PIN     = 9;
endpackage

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_chan_pkg::*;
#(
  parameter int DW     = 16,
  parameter int DIV_SW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [2*DW/8-1:0] bus_be,
  input  logic [2*DW-1:0]   bus_wdata,
  input  logic [DW-1:0]     cnt_cur,
  input  logic              flag_set,
  output logic [DW-1:0]     per_prim,
  output logic [DW-1:0]     wid_prim,
  output logic [DW-1:0]     ctrl_img,
  output logic              ctrl_en,
  output logic              ctrl_pol,
  output logic              ctrl_drv,
  output logic [DIV_SW-1:0] ctrl_div,
  output logic              flag,
  output logic              ctrl_wr,
  output logic              pair_wr,
  output logic              cnt_wr,
  output logic [DW-1:0]     cnt_wdata
);
  localparam int BE_W  = DW / 8;
  localparam int NREG  = 1 << REG_AW;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] nw,
                                                input logic [BE_W-1:0] be);
    logic [DW-1:0] r;
    r = cur;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  logic [NREG-1:0] hit;
  logic [DW-1:0]   wd [NREG];
  logic [BE_W-1:0] wb [NREG];
  logic [DW-1:0]   lo_d, hi_d;
  logic [BE_W-1:0] lo_b, hi_b;

  assign lo_d = bus_wdata[DW-1:0];
  assign hi_d = bus_wdata[2*DW-1:DW];
  assign lo_b = bus_be[BE_W-1:0];
  assign hi_b = bus_be[2*BE_W-1:BE_W];

  // route each half of an access to its register
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hit[i] = 1'b0;
      wd[i]  = lo_d;
      wb[i]  = lo_b;
      if (bus_wr) begin
        if (!bus_wide) begin
          if (bus_addr == REG_AW'(i)) hit[i] = 1'b1;
        end else if (!bus_addr[0]) begin
          if (bus_addr == REG_AW'(i)) begin
            hit[i] = 1'b1;
            wd[i]  = hi_d;
            wb[i]  = hi_b;
          end else if ({bus_addr[REG_AW-1:1], 1'b1} == REG_AW'(i)) begin
            hit[i] = 1'b1;
          end
        end
      end
    end
  end

  logic [DW-1:0] ctrl_new;

  always_comb begin
    ctrl_img = '0;
    ctrl_img[CB_EN]  = ctrl_en;
    ctrl_img[CB_POL] = ctrl_pol;
    ctrl_img[CB_DRV] = ctrl_drv;
    ctrl_img[CB_DIV_LO +: DIV_SW] = ctrl_div;
    ctrl_img[CB_FLAG] = flag;
  end

  assign ctrl_new  = merge_bytes(ctrl_img, wd[REG_CTRL], wb[REG_CTRL]);
  assign cnt_wdata = merge_bytes(cnt_cur, wd[REG_COUNT], wb[REG_COUNT]);
  assign cnt_wr    = hit[REG_COUNT];
  assign ctrl_wr   = hit[REG_CTRL];
  assign pair_wr   = bus_wr && bus_wide && (bus_addr == REG_PERIOD);

  // primaries have no reset: software initialises them
  always_ff @(posedge clk) begin
    if (hit[REG_COUNT])
      per_prim <= cnt_wdata;
    else if (hit[REG_PERIOD])
      per_prim <= merge_bytes(per_prim, wd[REG_PERIOD], wb[REG_PERIOD]);
    if (hit[REG_WIDTH])
      wid_prim <= merge_bytes(wid_prim, wd[REG_WIDTH], wb[REG_WIDTH]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_pol <= 1'b0;
      ctrl_drv <= 1'b0;
      ctrl_div <= '0;
    end else if (ctrl_wr) begin
      ctrl_en  <= ctrl_new[CB_EN];
      ctrl_pol <= ctrl_new[CB_POL];
      ctrl_drv <= ctrl_new[CB_DRV];
      ctrl_div <= ctrl_new[CB_DIV_LO +: DIV_SW];
    end
  end

  // a period end outranks a clearing write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag <= 1'b0;
    else if (flag_set)                   flag <= 1'b1;
    else if (ctrl_wr && !ctrl_new[CB_FLAG]) flag <= 1'b0;
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_SW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [DIV_SW-1:0] div_sel,
  output logic              tick
);
  localparam int DIV_W = (1 << DIV_SW) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = DIV_W'((32'd1 << div_sel) - 32'd1);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] per_prim,
  input  logic [DW-1:0] wid_prim,
  input  logic          pair_wr,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  output logic [DW-1:0] cnt_q,
  output logic          active,
  output logic          period_end
);
  localparam int CW = DW + 1;

  logic [DW-1:0] per_buf, wid_buf;
  logic          last;

  assign last       = (CW'(cnt_q) + CW'(1)) >= CW'(per_buf);
  assign period_end = run && tick && last;
  assign active     = cnt_q < wid_buf;

  always_ff @(posedge clk) begin
    if (cnt_wr)                cnt_q <= cnt_wdata;
    else if (run && tick)      cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  // buffers follow primaries while idle; refresh at boundary unless a pair write collides
  always_ff @(posedge clk) begin
    if (!run) begin
      per_buf <= per_prim;
      wid_buf <= wid_prim;
    end else if (period_end && !pair_wr) begin
      per_buf <= per_prim;
      wid_buf <= wid_prim;
    end
  end
endmodule

// File: rtl/pwm_coherent_chan.sv
module pwm_coherent_chan
  import pwm_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_SW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_wide,
  input  logic [1:0]            bus_addr,
  input  logic [2*DATA_W/8-1:0] bus_be,
  input  logic [2*DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  pin_in,
  output logic                  pin_out,
  output logic                  pin_oe,
  output logic                  req
);
  logic [DATA_W-1:0] per_prim, wid_prim, ctrl_img, cnt_q, cnt_wdata;
  logic              ctrl_en, ctrl_pol, ctrl_drv, flag;
  logic [DIV_SW-1:0] ctrl_div;
  logic              ctrl_wr, pair_wr, cnt_wr, tick, active;

  pwm_regbank #(.DW(DATA_W), .DIV_SW(DIV_SW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt_cur(cnt_q), .flag_set(req),
    .per_prim(per_prim), .wid_prim(wid_prim), .ctrl_img(ctrl_img),
    .ctrl_en(ctrl_en), .ctrl_pol(ctrl_pol), .ctrl_drv(ctrl_drv),
    .ctrl_div(ctrl_div), .flag(flag),
    .ctrl_wr(ctrl_wr), .pair_wr(pair_wr),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata)
  );

  pwm_prescaler #(.DIV_SW(DIV_SW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(ctrl_en), .restart(ctrl_wr),
    .div_sel(ctrl_div), .tick(tick)
  );

  pwm_core #(.DW(DATA_W)) u_core (
    .clk(clk), .run(ctrl_en), .tick(tick),
    .per_prim(per_prim), .wid_prim(wid_prim),
    .pair_wr(pair_wr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_q(cnt_q), .active(active), .period_end(req)
  );

  // pin: waveform when on, plain I/O when off
  assign pin_oe  = ctrl_en | ctrl_drv;
  assign pin_out = ctrl_en ? (active ? ctrl_pol : ~ctrl_pol) : ctrl_pol;

  always_comb begin
    unique case (reg_idx_e'(bus_addr))
      REG_PERIOD: bus_rdata = per_prim;
      REG_WIDTH:  bus_rdata = wid_prim;
      REG_COUNT:  bus_rdata = cnt_q;
      default: begin
        bus_rdata = ctrl_img;
        bus_rdata[CB_PIN] = pin_in;
      end
    endcase
  end
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int DW     = 16,
  parameter int DIV_SW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic              req,
  input logic              flag,
  input logic              ctrl_wr,
  input logic              cnt_wr,
  input logic              pin_oe,
  input logic              pin_out,
  input logic              pol,
  input logic              drv,
  input logic [DIV_SW-1:0] div_sel,
  input logic [DW-1:0]     cnt_q
);
  a_r2_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pin_oe == drv && pin_out == pol));

  a_r3_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> pin_oe);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cnt_wr) |=> (cnt_q == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !req && !cnt_wr) |=> (cnt_q == DW'($past(cnt_q) + 1'b1)));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (tick == (en && div_sel == '0)));

  a_r11_req_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (en && tick));

  a_r11_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> flag);

  a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !ctrl_wr) |=> $stable(flag));
endmodule

bind pwm_coherent_chan pwm_chan_checker #(.DW(DATA_W), .DIV_SW(DIV_SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick), .req(req),
  .flag(flag), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .pin_oe(pin_oe),
  .pin_out(pin_out), .pol(ctrl_pol), .drv(ctrl_drv), .div_sel(ctrl_div),
  .cnt_q(cnt_q)
);

// File: tb/tb_pwm_coherent_chan.sv
module tb_pwm_coherent_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_wide = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pin_in = 1'b0, pin_out, pin_oe, req;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_coherent_chan dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .req(req)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // writes: drive after a falling edge, hold through one rising edge
  task automatic wr16(logic [1:0] a, logic [15:0] d, logic [1:0] be);
    bus_wr = 1'b1; bus_wide = 1'b0; bus_addr = a;
    bus_wdata = {16'h0, d}; bus_be = {2'b00, be};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr32(logic [1:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_wide = 1'b1; bus_addr = a;
    bus_wdata = d; bus_be = 4'hF;
    @(negedge clk);
    bus_wr = 1'b0; bus_wide = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_req();
    int guard = 0;
    while (!req && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic align();
    wait_req();
    @(negedge clk);
  endtask

  // count from the current cycle up to and including the next req cycle
  task automatic measure(logic pol, output int len, output int act);
    len = 0; act = 0;
    forever begin
      len++;
      if (pin_out == pol) act++;
      if (req || len > 5000) break;
      @(negedge clk);
    end
  endtask

  task automatic setup(logic [15:0] per, logic [15:0] wid, logic [15:0] ctl);
    wr16(2'd3, 16'h0000, 2'b11);
    wr16(2'd2, 16'h0000, 2'b11);
    wr16(2'd0, per, 2'b11);
    wr16(2'd1, wid, 2'b11);
    wr16(2'd3, ctl, 2'b11);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd3, d);
    chk("R1 ctrl after reset", int'(d[8:0]), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 pin_out", int'(pin_out), 0);
    chk("R1 req", int'(req), 0);
  endtask

  task automatic t_idle_pin();
    logic [15:0] d;
    wr16(2'd3, 16'h0006, 2'b11);
    chk("R2 pin_out follows polarity", int'(pin_out), 1);
    chk("R2 pin_oe follows drive", int'(pin_oe), 1);
    wr16(2'd3, 16'h0000, 2'b11);
    chk("R2 pin_oe released", int'(pin_oe), 0);
    pin_in = 1'b1;
    rd(2'd3, d);
    chk("R2 pin level bit", int'(d[9]), 1);
    pin_in = 1'b0;
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr16(2'd2, 16'h0005, 2'b11);
    rd(2'd0, d); chk("R10 counter write loads period", int'(d), 5);
    rd(2'd2, d); chk("R10 counter readback", int'(d), 5);
    wr16(2'd0, 16'h1234, 2'b11);
    wr16(2'd0, 16'hAB00, 2'b10);
    rd(2'd0, d); chk("R7 high byte merge", int'(d), 'hAB34);
    wr32(2'd2, {16'h0009, 16'h0006});
    rd(2'd2, d); chk("R9 wide high half to counter", int'(d), 9);
    rd(2'd0, d); chk("R9 wide counter also sets period", int'(d), 9);
    rd(2'd3, d); chk("R9 wide low half to ctrl", int'(d[8:0]), 6);
    wr16(2'd1, 16'h0011, 2'b11);
    wr32(2'd1, 32'h7777_7777);
    rd(2'd1, d); chk("R9 odd wide ignored width", int'(d), 'h11);
    rd(2'd3, d); chk("R9 odd wide ignored ctrl", int'(d[8:0]), 6);
    wr16(2'd3, 16'h0000, 2'b11);
  endtask

  task automatic t_shapes();
    int len, act;
    setup(16'd4, 16'd1, 16'h0007);
    align(); measure(1'b1, len, act);
    chk("R3 period 4", len, 4); chk("R3 width 1", act, 1);
    chk("R3 pin driven", int'(pin_oe), 1);
    setup(16'd5, 16'd3, 16'h0007);
    align(); measure(1'b1, len, act);
    chk("R3 period 5", len, 5); chk("R3 width 3", act, 3);
    setup(16'd4, 16'd1, 16'h0005);
    align(); measure(1'b0, len, act);
    chk("R3 active-low width", act, 1);
    setup(16'd4, 16'd0, 16'h0007);
    align(); measure(1'b1, len, act);
    chk("R4 width zero", act, 0);
    setup(16'd4, 16'd9, 16'h0007);
    align(); measure(1'b1, len, act);
    chk("R4 width above period", act, 4);
  endtask

  task automatic t_divider();
    int len, act;
    setup(16'd3, 16'd1, 16'h0027);
    align(); measure(1'b1, len, act);
    chk("R5 divide by 4 period", len, 12);
    chk("R5 divide by 4 width", act, 4);
  endtask

  task automatic t_midwrite();
    int len, act;
    setup(16'd4, 16'd1, 16'h0007);
    align();
    wr16(2'd0, 16'd8, 2'b11);
    measure(1'b1, len, act);
    chk("R6 current period kept", len, 3);
    @(negedge clk); measure(1'b1, len, act);
    chk("R6 new period next", len, 8); chk("R6 width next", act, 1);
    setup(16'd4, 16'd1, 16'h0007);
    align();
    wr16(2'd0, 16'h0007, 2'b01);
    measure(1'b1, len, act);
    chk("R7 byte write not visible yet", len, 3);
    @(negedge clk); measure(1'b1, len, act);
    chk("R7 byte write whole word", len, 7);
  endtask

  task automatic t_pair();
    int len, act;
    setup(16'd4, 16'd1, 16'h0007);
    align();
    wr32(2'd0, {16'd5, 16'd2});
    wait_req();
    wr32(2'd0, {16'd6, 16'd3});
    measure(1'b1, len, act);
    chk("R8 boundary pair keeps old period", len, 4);
    chk("R8 boundary pair keeps old width", act, 1);
    @(negedge clk); measure(1'b1, len, act);
    chk("R8 pair loaded one period later", len, 6);
    chk("R8 pair width later", act, 3);
    align();
    wr32(2'd0, {16'd4, 16'd2});
    measure(1'b1, len, act);
    chk("R8 mid pair no effect", len, 5);
    @(negedge clk); measure(1'b1, len, act);
    chk("R8 mid pair next period", len, 4); chk("R8 mid pair next width", act, 2);
  endtask

  task automatic t_flag();
    logic [15:0] d;
    setup(16'd4, 16'd1, 16'h0007);
    align();
    chk("R11 req single cycle", int'(req), 0);
    rd(2'd3, d); chk("R11 flag set by period end", int'(d[8]), 1);
    wait_req();
    wr16(2'd3, 16'h0007, 2'b11);
    rd(2'd3, d); chk("R11 set beats clear", int'(d[8]), 1);
    wr16(2'd3, 16'h0000, 2'b01);
    wr16(2'd3, 16'h0100, 2'b10);
    rd(2'd3, d); chk("R11 writing one keeps flag", int'(d[8]), 1);
    wr16(2'd3, 16'h0000, 2'b10);
    rd(2'd3, d); chk("R11 writing zero clears", int'(d[8]), 0);
    wr16(2'd3, 16'h0100, 2'b10);
    rd(2'd3, d); chk("R11 writing one does not set", int'(d[8]), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_pin();
    t_regs();
    t_shapes();
    t_divider();
    t_midwrite();
    t_pair();
    t_flag();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule